// File: doc/BRIEF.md
# Cycle-Stealing Peripheral Transfer Controller

This block lets several peripheral controllers reach main memory through the processor's own datapath. Each device has a control word in memory at a fixed slot. The word holds a count of the transfers still to run and a current data address. When a device raises its request and wins arbitration, the block takes over the memory port for a four-beat steal. The steal fetches the control word, counts it down, moves its address on by one, and writes it back. It then either stores the device's incoming word or reads and rewrites the outgoing word, which it presents to the device. The count, the address and the stop decision are all worked out here, so the devices need no address logic of their own.

Steals normally start when the processor signals the end of an instruction, and they run in place of the next fetch. A device that wins its steal drops its request. Any other requester is served back to back before the processor resumes. A subset of the devices is fixed as urgent by a parameter. Their requests may also break into a long multiply or divide loop at one of its breakpoints. The block then saves the processor's two working registers to memory words 9 and 10 and serves the urgent requesters only. After that it reads both words back and hands them to the processor with a resume pulse. Steal addresses are not checked against any program's area. A device that finishes after its stop signal reports back, and this sets its sticky interrupt cause bit.

Top module: `cs_steal_ctrl`

## Requirements
- R1: When several devices request at once, the device with the lowest index wins. `dev_sel` is one-hot on the winner and zero outside a steal.
- R2: In the idle state a steal starts only on the clock edge that sees `instr_end` high with at least one request pending, or `brk_pt` high with an urgent request pending. Otherwise `cpu_hold` stays low. `cpu_hold` is high during every beat.
- R3: Beat 1 reads the control word of device i at address `CW_BASE + i`. The count is in bits 23:15 and the data address is in bits 14:0.
- R4: Beat 2 writes back the control word with the count lowered by one (held at zero if it was zero) and the address raised by one, wrapping from 0x7FFF to 0.
- R5: During beat 1, `dev_stop` is pulsed for the selected device when the count read is 0 or 1. It is not pulsed otherwise.
- R6: Beat 3 reads the word at the old data address. In beat 4, for an input device (`dev_dir` = 1) `in_data` is written there. For an output device the word read is written back unchanged, and it is shown on `out_data` with `out_valid` high.
- R7: `dev_sel` stays constant through all four beats of a steal.
- R8: At the end of beat 4, if requests remain, the next steal starts at once with no idle cycle. If none remain, the block returns to idle.
- R9: A breakpoint entry writes `reg_a` to word 9 and then `reg_b` to word 10, and then serves only urgent devices (those set in `URG_MASK`), back to back.
- R10: When no urgent request remains, the block reads word 9 and then word 10. In the next cycle it pulses `resume` with those values on `rest_a` and `rest_b`.
- R11: `brk_pt` with only non-urgent requests pending is ignored: no hold, no select, no memory write.
- R12: `dev_done[i]` sets `cause[i]` from the next cycle onward. `cause_ack[i]` clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | N_DEV | Per-device steal request |
| dev_dir | input | N_DEV | Per-device direction, 1 = data into memory |
| dev_done | input | N_DEV | Per-device transfer-finished pulse |
| cause_ack | input | N_DEV | Per-device cause clear |
| in_data | input | DW | Incoming word from the selected device |
| instr_end | input | 1 | Processor is at an instruction boundary |
| brk_pt | input | 1 | Processor is at a breakpoint inside a long loop |
| reg_a | input | DW | First working register to save |
| reg_b | input | DW | Second working register to save |
| dev_sel | output | N_DEV | One-hot select of the device being served |
| dev_stop | output | N_DEV | Last-transfer signal, beat 1 |
| cause | output | N_DEV | Sticky per-device interrupt cause |
| out_data | output | DW | Outgoing word for the selected device |
| out_valid | output | 1 | `out_data` is valid (beat 4, output device) |
| cpu_hold | output | 1 | Processor must wait |
| resume | output | 1 | Restored registers are valid |
| rest_a | output | DW | Restored first register |
| rest_b | output | DW | Restored second register |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read, data returned combinationally |
| mem_wr | output | 1 | Memory write at the clock edge |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the block with four devices, of which devices 0 and 1 are urgent, and with control words at 16 to 19. This makes fixed priority among all four devices observable. It also allows breakpoint runs in which urgent and non-urgent requests are pending together, so the non-urgent one can be seen to wait. With a 24-bit word and a 15-bit address, the bench can reach count saturation at zero, the stop on counts 0 and 1, and the address wrap at 0x7FFF. Random control words, directions and request sets are mixed with these directed cases.

// File: rtl/cs_pkg.sv
// Shared types for the cycle-stealing controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAVE_A,
        ST_SAVE_B,
        ST_B1,
        ST_B2,
        ST_B3,
        ST_B4,
        ST_REST_A,
        ST_REST_B
    } cs_state_e;
endpackage

// File: rtl/cs_prio_arb.sv
// Fixed-priority picker: the lowest set index wins.
// Assumes: N >= 2; the output is purely combinational.
module cs_prio_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from high to low so that the lowest requester is written last.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cs_cw_update.sv
// Control word arithmetic: count down (saturating), address up (wrapping).
// Assumes: count in the upper DW-AW bits, address in the lower AW bits.
module cs_cw_update #(
    parameter int DW = 24,
    parameter int AW = 15
) (
    input  logic [DW-1:0] cw,
    output logic [DW-1:0] cw_nxt,
    output logic          last
);
    localparam int CW_W = DW - AW;

    logic [CW_W-1:0] cnt;
    logic [AW-1:0]   adr;

    // Split the word, decide on the stop and build the updated word.
    always_comb begin
        cnt    = cw[DW-1:AW];
        adr    = cw[AW-1:0];
        last   = (cnt <= CW_W'(1));
        cw_nxt = {(cnt == '0) ? cnt : cnt - CW_W'(1), adr + AW'(1)};
    end
endmodule

// File: rtl/cs_cause_bits.sv
// Sticky per-device interrupt cause bits; a set wins over a clear.
// Assumes: done and ack are synchronous single-cycle pulses.
module cs_cause_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] done,
    input  logic [N-1:0] ack,
    output logic [N-1:0] cause
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Hold, set or clear one cause bit.
        always_ff @(posedge clk) begin
            if (!rst_n)       cause[g] <= 1'b0;
            else if (done[g]) cause[g] <= 1'b1;
            else if (ack[g])  cause[g] <= 1'b0;
        end

        // R12
        cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done[g] |=> cause[g]);
    end
endmodule

// File: rtl/cs_steal_ctrl.sv
// Cycle-stealing transfer controller: arbitrates device requests and runs
// four-beat steals on the shared memory port, with breakpoint entry that
// saves and restores two processor registers.
// Assumes: memory read data is combinational on mem_addr; the processor
// keeps reg_a/reg_b stable while cpu_hold is high; a device drops its
// request once it sees its select.
module cs_steal_ctrl #(
    parameter int          N_DEV    = 4,
    parameter int          DW       = 24,
    parameter int          AW       = 15,
    parameter int          CW_BASE  = 16,
    parameter int          SAVE_A   = 9,
    parameter int          SAVE_B   = 10,
    parameter logic [N_DEV-1:0] URG_MASK = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_DEV-1:0] dev_dir,
    input  logic [N_DEV-1:0] dev_done,
    input  logic [N_DEV-1:0] cause_ack,
    input  logic [DW-1:0]    in_data,
    input  logic             instr_end,
    input  logic             brk_pt,
    input  logic [DW-1:0]    reg_a,
    input  logic [DW-1:0]    reg_b,
    output logic [N_DEV-1:0] dev_sel,
    output logic [N_DEV-1:0] dev_stop,
    output logic [N_DEV-1:0] cause,
    output logic [DW-1:0]    out_data,
    output logic             out_valid,
    output logic             cpu_hold,
    output logic             resume,
    output logic [DW-1:0]    rest_a,
    output logic [DW-1:0]    rest_b,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    import cs_pkg::*;

    localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    cs_state_e        st;
    logic [N_DEV-1:0] gnt_q;
    logic [IW-1:0]    gidx_q;
    logic             in_loop;
    logic [DW-1:0]    cw_new_q;
    logic [AW-1:0]    daddr_q;
    logic [DW-1:0]    data_q;
    logic [AW-1:0]    cw_addr;
    logic             in_steal;

    logic [N_DEV-1:0] all_gnt, urg_gnt;
    logic [IW-1:0]    all_idx, urg_idx;
    logic             all_any, urg_any;
    logic [DW-1:0]    cw_nxt;
    logic             cw_last;

    cs_prio_arb #(.N(N_DEV)) u_arb_all (
        .req(dev_req), .gnt(all_gnt), .idx(all_idx), .any(all_any));

    cs_prio_arb #(.N(N_DEV)) u_arb_urg (
        .req(dev_req & URG_MASK), .gnt(urg_gnt), .idx(urg_idx), .any(urg_any));

    cs_cw_update #(.DW(DW), .AW(AW)) u_cw (
        .cw(mem_rdata), .cw_nxt(cw_nxt), .last(cw_last));

    cs_cause_bits #(.N(N_DEV)) u_cause (
        .clk(clk), .rst_n(rst_n), .done(dev_done), .ack(cause_ack), .cause(cause));

    assign cw_addr  = AW'(CW_BASE) + AW'(gidx_q);
    assign in_steal = (st == ST_B1) || (st == ST_B2) || (st == ST_B3) || (st == ST_B4);
    assign cpu_hold = (st != ST_IDLE);
    assign dev_sel  = in_steal ? gnt_q : '0;
    assign dev_stop = ((st == ST_B1) && cw_last) ? gnt_q : '0;
    assign out_data = data_q;
    assign out_valid = (st == ST_B4) && !dev_dir[gidx_q];

    // Sequence the beats and choose the next steal or the way out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            gnt_q   <= '0;
            gidx_q  <= '0;
            in_loop <= 1'b0;
            cw_new_q <= '0;
            daddr_q <= '0;
            data_q  <= '0;
            rest_a  <= '0;
            rest_b  <= '0;
            resume  <= 1'b0;
        end else begin
            resume <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (instr_end && all_any) begin
                        st <= ST_B1; gnt_q <= all_gnt; gidx_q <= all_idx; in_loop <= 1'b0;
                    end else if (brk_pt && urg_any) begin
                        st <= ST_SAVE_A; in_loop <= 1'b1;
                    end
                end
                ST_SAVE_A: st <= ST_SAVE_B;
                ST_SAVE_B: begin
                    if (urg_any) begin
                        st <= ST_B1; gnt_q <= urg_gnt; gidx_q <= urg_idx;
                    end else begin
                        st <= ST_REST_A;
                    end
                end
                ST_B1: begin
                    cw_new_q <= cw_nxt;
                    daddr_q  <= mem_rdata[AW-1:0];
                    st       <= ST_B2;
                end
                ST_B2: st <= ST_B3;
                ST_B3: begin
                    data_q <= mem_rdata;
                    st     <= ST_B4;
                end
                ST_B4: begin
                    if (in_loop) begin
                        if (urg_any) begin
                            st <= ST_B1; gnt_q <= urg_gnt; gidx_q <= urg_idx;
                        end else begin
                            st <= ST_REST_A;
                        end
                    end else if (all_any) begin
                        st <= ST_B1; gnt_q <= all_gnt; gidx_q <= all_idx;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_REST_A: begin
                    rest_a <= mem_rdata;
                    st     <= ST_REST_B;
                end
                ST_REST_B: begin
                    rest_b  <= mem_rdata;
                    resume  <= 1'b1;
                    in_loop <= 1'b0;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port for the current beat.
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        unique case (st)
            ST_SAVE_A: begin mem_addr = AW'(SAVE_A); mem_wr = 1'b1; mem_wdata = reg_a; end
            ST_SAVE_B: begin mem_addr = AW'(SAVE_B); mem_wr = 1'b1; mem_wdata = reg_b; end
            ST_B1:     begin mem_addr = cw_addr; mem_rd = 1'b1; end
            ST_B2:     begin mem_addr = cw_addr; mem_wr = 1'b1; mem_wdata = cw_new_q; end
            ST_B3:     begin mem_addr = daddr_q; mem_rd = 1'b1; end
            ST_B4:     begin
                mem_addr  = daddr_q;
                mem_wr    = 1'b1;
                mem_wdata = dev_dir[gidx_q] ? in_data : data_q;
            end
            ST_REST_A: begin mem_addr = AW'(SAVE_A); mem_rd = 1'b1; end
            ST_REST_B: begin mem_addr = AW'(SAVE_B); mem_rd = 1'b1; end
            default: ;
        endcase
    end

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    // R1
    sel_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_sel != '0) |-> ((dev_sel & $past(dev_req)) != '0));

    // R2
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold) |-> ($past(instr_end) || $past(brk_pt)));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_B2) || (st == ST_B3) || (st == ST_B4)) |-> (dev_sel == $past(dev_sel)));

    // R5
    stop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_stop != '0) |-> ((st == ST_B1) && (dev_stop == dev_sel)));

    // R9
    loop_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && (dev_sel != '0)) |-> ((dev_sel & ~URG_MASK) == '0));

    // R6
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/cs_steal_ctrl_bench.sv
`timescale 1ns/1ps
module cs_steal_ctrl_bench;
    localparam int N = 4;
    localparam int DW = 24;
    localparam int AW = 15;
    localparam int CWB = 16;
    localparam logic [3:0] URG = 4'b0011;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [N-1:0] dev_req, dev_dir, dev_done, cause_ack;
    logic [DW-1:0] in_data, reg_a, reg_b;
    logic instr_end, brk_pt;
    logic [N-1:0] dev_sel, dev_stop, cause;
    logic [DW-1:0] out_data, rest_a, rest_b, mem_wdata, mem_rdata;
    logic out_valid, cpu_hold, resume, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;

    logic [DW-1:0] mem [0:1023];
    logic [DW-1:0] exp_mem [0:1023];

    int n_chk = 0;
    int n_fail = 0;

    cs_steal_ctrl #(.N_DEV(N), .DW(DW), .AW(AW), .CW_BASE(CWB),
                    .SAVE_A(9), .SAVE_B(10), .URG_MASK(URG)) u_cs_steal_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_dir(dev_dir),
        .dev_done(dev_done), .cause_ack(cause_ack), .in_data(in_data),
        .instr_end(instr_end), .brk_pt(brk_pt), .reg_a(reg_a), .reg_b(reg_b),
        .dev_sel(dev_sel), .dev_stop(dev_stop), .cause(cause),
        .out_data(out_data), .out_valid(out_valid), .cpu_hold(cpu_hold),
        .resume(resume), .rest_a(rest_a), .rest_b(rest_b),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [DW-1:0] v);
        mem[a[9:0]] = v;
        exp_mem[a[9:0]] = v;
    endtask

    function automatic logic [DW-1:0] cw_next(input logic [DW-1:0] cw);
        logic [8:0] c;
        c = cw[23:15];
        return {(c == 9'd0) ? 9'd0 : c - 9'd1, cw[14:0] + 15'd1};
    endfunction

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = N - 1; i >= 0; i--) if (r[i]) lowest = i;
    endfunction

    // Entered at the falling edge inside beat 1; returns one cycle after beat 4.
    task automatic steal_one(input int i);
        int cwa;
        logic [DW-1:0] cw;
        logic [9:0] da;
        logic last;
        logic [N-1:0] oh;
        cwa = CWB + i;
        cw = exp_mem[cwa];
        da = cw[9:0];
        last = (cw[23:15] <= 9'd1);
        oh = N'(1) << i;
        chk(dev_sel == oh, "R1 winner select", 32'(dev_sel), 32'(oh));
        chk(dev_stop == (last ? oh : '0), "R5 stop", 32'(dev_stop), 32'(last ? oh : '0));
        chk(mem_rd && mem_addr == AW'(cwa), "R3 cw read addr", 32'(mem_addr), 32'(cwa));
        chk(cpu_hold, "R2 hold in beat", 32'(cpu_hold), 32'd1);
        dev_req[i] = 1'b0;
        exp_mem[cwa] = cw_next(cw);
        @(negedge clk);
        chk(dev_sel == oh, "R7 beat2 sel", 32'(dev_sel), 32'(oh));
        @(negedge clk);
        chk(dev_sel == oh, "R7 beat3 sel", 32'(dev_sel), 32'(oh));
        @(negedge clk);
        chk(dev_sel == oh, "R7 beat4 sel", 32'(dev_sel), 32'(oh));
        if (dev_dir[i]) exp_mem[da] = in_data;
        else chk(out_valid && out_data == exp_mem[da], "R6 out word", 32'(out_data), 32'(exp_mem[da]));
        @(negedge clk);
        chk(mem[cwa] == exp_mem[cwa], "R4 cw writeback", 32'(mem[cwa]), 32'(exp_mem[cwa]));
        chk(mem[da] == exp_mem[da], "R6 data word", 32'(mem[da]), 32'(exp_mem[da]));
    endtask

    // Serves a request set from an instruction boundary, lowest index first.
    task automatic run_set(input logic [N-1:0] r);
        logic [N-1:0] pend;
        pend = r;
        dev_req = r;
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        while (pend != '0) begin
            int i;
            i = lowest(pend);
            pend[i] = 1'b0;
            steal_one(i);
        end
        chk(!cpu_hold && dev_sel == '0, "R8 back to idle", 32'(cpu_hold), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] ra, rb;
        void'($urandom(32'd4242));
        for (int k = 0; k < 1024; k++) begin mem[k] = '0; exp_mem[k] = '0; end
        rst_n = 1'b0; dev_req = '0; dev_dir = '0; dev_done = '0; cause_ack = '0;
        in_data = '0; instr_end = 1'b0; brk_pt = 1'b0; reg_a = '0; reg_b = '0;
        repeat (3) @(negedge clk);
        chk(!cpu_hold && dev_sel == '0 && cause == '0, "R2 reset state", 32'(cpu_hold), 32'd0);
        rst_n = 1'b1;

        // R2: a pending request waits for the instruction boundary.
        poke(CWB + 2, {9'd5, 15'h0210});
        poke(16'h210, 24'hABCDEF);
        dev_req = 4'b0100; dev_dir = 4'b0100; in_data = 24'h123456;
        repeat (3) begin
            @(negedge clk);
            chk(!cpu_hold && dev_sel == '0, "R2 no start without boundary", 32'(cpu_hold), 32'd0);
        end
        run_set(4'b0100);

        // R5/R4: count one, count zero (saturates), address wrap, output direction.
        poke(CWB + 0, {9'd1, 15'h0300});
        poke(16'h300, 24'h0F0F0F);
        dev_dir = 4'b0000;
        run_set(4'b0001);
        run_set(4'b0001);
        chk(mem[CWB] == {9'd0, 15'h0302}, "R4 saturate at zero", 32'(mem[CWB]), 32'({9'd0, 15'h0302}));
        poke(CWB + 3, {9'd3, 15'h7FFF});
        poke(16'h3FF, 24'h55AA55);
        dev_dir = 4'b1000; in_data = 24'h777777;
        run_set(4'b1000);
        chk(mem[CWB + 3] == {9'd2, 15'h0000}, "R4 address wrap", 32'(mem[CWB + 3]), 32'({9'd2, 15'h0000}));

        // R1/R8: random request sets served back to back in priority order.
        for (int it = 0; it < 30; it++) begin
            logic [N-1:0] r;
            for (int d = 0; d < N; d++) begin
                poke(CWB + d, {9'($urandom_range(0, 7)), 15'h0200 | 15'($urandom_range(0, 255)) | 15'(d << 8)});
                poke(exp_mem[CWB + d][9:0], DW'($urandom));
            end
            r = N'($urandom_range(1, 15));
            dev_dir = N'($urandom);
            in_data = DW'($urandom);
            run_set(r);
        end

        // R11: breakpoint with only non-urgent requests is ignored.
        dev_req = 4'b1100;
        brk_pt = 1'b1;
        @(negedge clk);
        brk_pt = 1'b0;
        chk(!cpu_hold && !mem_wr && dev_sel == '0, "R11 ignored breakpoint", 32'(cpu_hold), 32'd0);
        @(negedge clk);
        chk(!cpu_hold && !mem_wr, "R11 still idle", 32'(cpu_hold), 32'd0);
        dev_req = '0;

        // R9/R10: breakpoint entry, urgent-only service, restore.
        for (int d = 0; d < N; d++) begin
            poke(CWB + d, {9'd4, 15'h0280 + 15'(d * 16)});
            poke(16'h280 + d * 16, 24'h100000 + DW'(d));
        end
        ra = DW'($urandom); rb = DW'($urandom);
        reg_a = ra; reg_b = rb;
        dev_dir = 4'b0101; in_data = 24'hC0FFEE;
        dev_req = 4'b0111;
        brk_pt = 1'b1;
        @(negedge clk);
        brk_pt = 1'b0;
        chk(mem_wr && mem_addr == 15'd9 && mem_wdata == ra, "R9 save first", 32'(mem_addr), 32'd9);
        @(negedge clk);
        chk(mem_wr && mem_addr == 15'd10 && mem_wdata == rb, "R9 save second", 32'(mem_addr), 32'd10);
        @(negedge clk);
        steal_one(0);
        steal_one(1);
        chk(dev_sel == '0 && mem_rd && mem_addr == 15'd9, "R10 restore read", 32'(mem_addr), 32'd9);
        chk(mem[9] == ra && mem[10] == rb, "R9 saved words", 32'(mem[9]), 32'(ra));
        reg_a = '0; reg_b = '0;
        @(negedge clk);
        @(negedge clk);
        chk(resume && rest_a == ra, "R10 resume first", 32'(rest_a), 32'(ra));
        chk(rest_b == rb, "R10 resume second", 32'(rest_b), 32'(rb));
        chk(dev_req[2] && dev_sel == '0, "R9 non-urgent left waiting", 32'(dev_sel), 32'd0);
        run_set(4'b0100);

        // R12: cause set, clear, and set winning over clear.
        dev_done = 4'b1000;
        @(negedge clk);
        dev_done = '0;
        chk(cause == 4'b1000, "R12 cause set", 32'(cause), 32'h8);
        cause_ack = 4'b1000;
        @(negedge clk);
        cause_ack = '0;
        chk(cause == 4'b0000, "R12 cause clear", 32'(cause), 32'h0);
        dev_done = 4'b0010; cause_ack = 4'b0010;
        @(negedge clk);
        dev_done = '0; cause_ack = '0;
        chk(cause == 4'b0010, "R12 set wins", 32'(cause), 32'h2);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule